// File: doc/BRIEF.md
# Dual-Mode Serial Converter Port

This block is the device-side serial interface of a 10-bit sampling converter. A fast system clock oversamples an external serial clock, an active-low select strobe and a serial data input. The select strobe serves as chip select in microprocessor framing and as frame sync in DSP framing. A mode pin chooses the framing, and a clock-invert strap chooses which serial-clock edge captures the incoming address. Output timing does not depend on the strap.

During each frame the port takes a 4-bit channel address, most significant bit first. At the same time it shifts out the previous 10-bit result, most significant bit first. It opens a sample window and then hands control to a stub conversion sequencer with a one-cycle start pulse. The sequencer stays busy for a fixed number of system clocks. It then builds the next result word from six upper data bits supplied on a parallel input and the latched channel number, and raises done for one cycle. If the strobe goes inactive before the handoff edge, the frame is aborted.

Top module: `adcsp_top`

## Requirements
- R1: After reset the serial output is disabled, the sample window is closed, busy and channel-valid are low, and the stored result word is zero.
- R2: Address bits are captured most significant bit first on serial-clock rising edges when the mode pin and the strap differ (mode 1 = DSP, strap 1 = inverted), and on falling edges when they are equal.
- R3: The channel-valid flag goes high after the fourth capture edge, with the captured address on the channel output. It is cleared when the next frame starts.
- R4: In microprocessor mode the output reads 0 after the select falls, and falling edge n (1 to 10) presents result bit 10-n. In DSP mode the output presents bit 9 when the select falls, rising edge n (1 to 9) presents bit 9-n, and rising edge 10 drives 0. The strap has no effect on this.
- R5: The sample window opens on the fourth falling edge and closes on the tenth rising edge in microprocessor mode. In DSP mode it opens on the fourth rising edge and closes on the tenth falling edge.
- R6: A frame that reaches its closing edge issues exactly one conversion-start pulse, on that edge.
- R7: A select that goes inactive before the closing edge issues no start pulse, closes the window and resets the edge counters. The stored result word stays unchanged.
- R8: The output enable is high exactly while the synchronized select is active.
- R9: After a start pulse, busy stays high for CONV_CYCLES system clocks. Done then pulses for one cycle, and the stored result becomes {data_hi, channel}. The next frame shifts this word out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_pin | input | 1 | External serial clock |
| sel_n_pin | input | 1 | Active-low chip select or frame sync |
| sdi_pin | input | 1 | Serial address input |
| inv_strap | input | 1 | Clock-invert strap, static during a frame |
| dsp_mode | input | 1 | 1 = DSP framing, 0 = microprocessor framing |
| data_hi_in | input | 6 | Upper result bits delivered by the converter core |
| sdo | output | 1 | Serial result output |
| sdo_en | output | 1 | Output enable (low means high impedance) |
| chan_addr | output | 4 | Captured channel address |
| chan_valid | output | 1 | Channel address complete for this frame |
| samp_win | output | 1 | Sample window flag |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_busy | output | 1 | Stub sequencer busy |
| conv_done | output | 1 | One-cycle conversion done pulse |

## Verification
The bench runs all four mode and strap combinations. A design that captured on the wrong edge would assemble a shifted or smeared address, because the data line changes between frames. Output bits are compared after every serial edge, so an off-by-one launch count would show up in DSP mode as a missing leading bit and in microprocessor mode as a duplicated leading bit. The window is compared after both edges of every period, which catches an open or close on the wrong polarity. Aborts are placed just before the closing edge, and the following frame must still shift out the old word. A design that leaked a start pulse or failed to reset its counters would therefore fail.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;
  localparam int RES_W       = 10;
  localparam int ADDR_W      = 4;
  localparam int FRAME_EDGES = 10;

  // capture edge polarity: rising when framing mode and strap differ
  function automatic logic capture_on_rise(input logic dsp, input logic inv);
    return dsp ^ inv;
  endfunction

  // the window opens and data launches on rising edges only in DSP framing
  function automatic logic opens_on_rise(input logic dsp);
    return dsp;
  endfunction

  // the window closes and control is handed off on the opposite polarity
  function automatic logic closes_on_rise(input logic dsp);
    return ~dsp;
  endfunction
endpackage

// File: rtl/adcsp_sync_chain.sv
module adcsp_sync_chain #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/adcsp_frame_ctrl.sv
module adcsp_frame_ctrl
  import adcsp_pkg::*;
#(
  parameter int RW = RES_W,
  parameter int AW = ADDR_W,
  parameter int EDGES = FRAME_EDGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          sel_n_s,
  input  logic          sdi_s,
  input  logic          dsp,
  input  logic          inv,
  input  logic [RW-1:0] word_in,
  output logic          sdo,
  output logic          sdo_en,
  output logic [AW-1:0] chan_addr,
  output logic          chan_valid,
  output logic          samp_win,
  output logic          conv_start
);
  localparam int CW = $clog2(EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(EDGES);
  localparam logic [CW-1:0] ADDR_EDGES = CW'(AW);

  logic sclk_p, sel_p;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      sel_p  <= 1'b1;
    end else begin
      sclk_p <= sclk_s;
      sel_p  <= sel_n_s;
    end
  end

  // named internal events
  logic sclk_r, sclk_f, start_evt, end_evt, in_frame;
  logic rise_evt, fall_evt, cap_rise, cap_evt, cap_take, cap_last;
  logic open_evt, hand_evt, launch_evt, abort_evt;
  logic frame_act, handed;
  logic [CW-1:0] rise_cnt, fall_cnt, cap_cnt;
  logic [RW:0] out_sh;

  assign sclk_r    = sclk_s & ~sclk_p;
  assign sclk_f    = ~sclk_s & sclk_p;
  assign start_evt = ~sel_n_s & sel_p;
  assign end_evt   = sel_n_s & ~sel_p;
  assign in_frame  = frame_act & ~end_evt;
  assign rise_evt  = in_frame & sclk_r & (rise_cnt != LAST);
  assign fall_evt  = in_frame & sclk_f & (fall_cnt != LAST);

  always_comb begin
    cap_rise = capture_on_rise(dsp, inv);
    cap_evt  = cap_rise ? rise_evt : fall_evt;
    cap_cnt  = cap_rise ? rise_cnt : fall_cnt;
    cap_take = cap_evt && (cap_cnt < ADDR_EDGES);
    cap_last = cap_take && (cap_cnt == ADDR_EDGES - 1'b1);
    open_evt = opens_on_rise(dsp) ? (rise_evt && rise_cnt == ADDR_EDGES - 1'b1)
                                  : (fall_evt && fall_cnt == ADDR_EDGES - 1'b1);
    hand_evt = ~handed && (closes_on_rise(dsp) ? (rise_evt && rise_cnt == LAST - 1'b1)
                                               : (fall_evt && fall_cnt == LAST - 1'b1));
    launch_evt = opens_on_rise(dsp) ? rise_evt : fall_evt;
    abort_evt  = end_evt & frame_act & ~handed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_act  <= 1'b0;
      handed     <= 1'b0;
      rise_cnt   <= '0;
      fall_cnt   <= '0;
      samp_win   <= 1'b0;
      conv_start <= 1'b0;
      chan_addr  <= '0;
      chan_valid <= 1'b0;
      out_sh     <= '0;
    end else begin
      conv_start <= hand_evt;
      if (start_evt) begin
        frame_act  <= 1'b1;
        handed     <= 1'b0;
        rise_cnt   <= '0;
        fall_cnt   <= '0;
        samp_win   <= 1'b0;
        chan_valid <= 1'b0;
        out_sh     <= dsp ? {word_in, 1'b0} : {1'b0, word_in};
      end else if (end_evt) begin
        frame_act <= 1'b0;
        rise_cnt  <= '0;
        fall_cnt  <= '0;
        samp_win  <= 1'b0;
      end else begin
        if (rise_evt) rise_cnt <= rise_cnt + 1'b1;
        if (fall_evt) fall_cnt <= fall_cnt + 1'b1;
        if (hand_evt) begin
          handed   <= 1'b1;
          samp_win <= 1'b0;
        end else if (open_evt) begin
          samp_win <= 1'b1;
        end
        if (cap_take) chan_addr <= {chan_addr[AW-2:0], sdi_s};
        if (cap_last) chan_valid <= 1'b1;
        if (launch_evt) out_sh <= {out_sh[RW-1:0], 1'b0};
      end
    end
  end

  assign sdo    = out_sh[RW];
  assign sdo_en = frame_act;

  a_r6_handoff_closes_window: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !samp_win);
  a_r5_window_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    samp_win |-> sdo_en);
  a_r3_address_before_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> chan_valid);
  a_r7_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!conv_start && !samp_win && rise_cnt == '0 && fall_cnt == '0));
  a_r8_enable_follows_select: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> sdo_en);
endmodule

// File: rtl/adcsp_conv_stub.sv
module adcsp_conv_stub
  import adcsp_pkg::*;
#(
  parameter int RW = RES_W,
  parameter int AW = ADDR_W,
  parameter int CONV_CYCLES = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            conv_start,
  input  logic [AW-1:0]   chan_in,
  input  logic [RW-AW-1:0] data_hi_in,
  output logic            busy,
  output logic            done,
  output logic [RW-1:0]   result_word
);
  localparam int TW = $clog2(CONV_CYCLES + 1);
  logic [TW-1:0] tmr;
  logic [AW-1:0] chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      tmr         <= '0;
      chan_q      <= '0;
      result_word <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && conv_start) begin
        busy   <= 1'b1;
        tmr    <= TW'(CONV_CYCLES - 1);
        chan_q <= chan_in;
      end else if (busy) begin
        if (tmr == '0) begin
          busy        <= 1'b0;
          done        <= 1'b1;
          result_word <= {data_hi_in, chan_q};
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
    end
  end

  a_r9_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !busy) |=> busy);
  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/adcsp_top.sv
module adcsp_top
  import adcsp_pkg::*;
#(
  parameter int CONV_CYCLES = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_pin,
  input  logic                  sel_n_pin,
  input  logic                  sdi_pin,
  input  logic                  inv_strap,
  input  logic                  dsp_mode,
  input  logic [RES_W-ADDR_W-1:0] data_hi_in,
  output logic                  sdo,
  output logic                  sdo_en,
  output logic [ADDR_W-1:0]     chan_addr,
  output logic                  chan_valid,
  output logic                  samp_win,
  output logic                  conv_start,
  output logic                  conv_busy,
  output logic                  conv_done
);
  logic [2:0] pins_s;
  logic [RES_W-1:0] result_word;

  adcsp_sync_chain #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sel_n_pin, sclk_pin, sdi_pin}),
    .q    (pins_s)
  );

  adcsp_frame_ctrl #(.RW(RES_W), .AW(ADDR_W), .EDGES(FRAME_EDGES)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[1]),
    .sel_n_s   (pins_s[2]),
    .sdi_s     (pins_s[0]),
    .dsp       (dsp_mode),
    .inv       (inv_strap),
    .word_in   (result_word),
    .sdo       (sdo),
    .sdo_en    (sdo_en),
    .chan_addr (chan_addr),
    .chan_valid(chan_valid),
    .samp_win  (samp_win),
    .conv_start(conv_start)
  );

  adcsp_conv_stub #(.RW(RES_W), .AW(ADDR_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .chan_in    (chan_addr),
    .data_hi_in (data_hi_in),
    .busy       (conv_busy),
    .done       (conv_done),
    .result_word(result_word)
  );
endmodule

// File: tb/sim_adcsp_top.sv
`timescale 1ns/1ps
module sim_adcsp_top;
  localparam int CONV = 20;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sel_n = 1, sdi = 0, inv = 0, dsp = 0;
  logic [5:0] dhi = '0;
  logic sdo, sdo_en, chan_valid, samp_win, conv_start, conv_busy, conv_done;
  logic [3:0] chan_addr;
  int total = 0, bad = 0;
  int starts = 0, dones = 0, busy_run = 0;
  logic [9:0] exp_word = '0;

  always #2 clk = ~clk;

  adcsp_top #(.CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk), .sel_n_pin(sel_n), .sdi_pin(sdi),
    .inv_strap(inv), .dsp_mode(dsp), .data_hi_in(dhi), .sdo(sdo), .sdo_en(sdo_en),
    .chan_addr(chan_addr), .chan_valid(chan_valid), .samp_win(samp_win),
    .conv_start(conv_start), .conv_busy(conv_busy), .conv_done(conv_done));

  always @(posedge clk) begin
    if (conv_start) begin starts <= starts + 1; busy_run <= 0; end
    else if (conv_busy) busy_run <= busy_run + 1;
    if (conv_done) dones <= dones + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_sdo(input logic d, input logic [9:0] w, input int launches);
    if (d) return (launches <= 9) ? int'(w[9-launches]) : 0;
    return (launches == 0) ? 0 : int'(w[10-launches]);
  endfunction

  function automatic int exp_win(input logic d, input int r, input int f);
    if (d) return (r >= 4 && f < 10) ? 1 : 0;
    return (f >= 4 && r < 10) ? 1 : 0;
  endfunction

  task automatic edge_checks(input logic [3:0] addr, input int r, input int f);
    int caps;
    caps = (dsp ^ inv) ? r : f;
    chk("R4 sdo", int'(sdo), exp_sdo(dsp, exp_word, dsp ? r : f));
    chk("R5 window", int'(samp_win), exp_win(dsp, r, f));
    chk("R3 valid", int'(chan_valid), caps >= 4 ? 1 : 0);
    if (caps >= 4) chk("R2 address", int'(chan_addr), int'(addr));
  endtask

  // periods: number of full serial periods before select rises (10 = complete)
  task automatic frame(input logic d, input logic iv, input logic [3:0] addr, input int periods);
    int s0, d0;
    dsp = d; inv = iv;
    dhi = 6'($urandom);
    s0 = starts; d0 = dones;
    wclk(4);
    sel_n = 0;
    wclk(8);
    chk("R8 enable on", int'(sdo_en), 1);
    chk("R3 valid cleared", int'(chan_valid), 0);
    chk("R4 first bit", int'(sdo), exp_sdo(d, exp_word, 0));
    for (int k = 1; k <= periods; k++) begin
      sdi = (k <= 4) ? addr[4-k] : 1'($urandom);
      wclk(4);
      sclk = 1; wclk(6);
      edge_checks(addr, k, k - 1);
      sclk = 0; wclk(6);
      edge_checks(addr, k, k);
    end
    sel_n = 1;
    wclk(8);
    chk("R8 enable off", int'(sdo_en), 0);
    chk("R7 window shut", int'(samp_win), 0);
    if (periods >= 10) begin
      chk("R6 one start", starts - s0, 1);
      for (int w = 0; w < 200 && dones == d0; w++) wclk(1);
      chk("R9 done", dones - d0, 1);
      chk("R9 busy length", busy_run, CONV);
      exp_word = {dhi, addr};
    end else begin
      wclk(CONV + 10);
      chk("R7 no start", starts - s0, 0);
      chk("R7 no busy", dones - d0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1544));
    wclk(5);
    rst_n = 1;
    wclk(3);
    chk("R1 enable", int'(sdo_en), 0);
    chk("R1 window", int'(samp_win), 0);
    chk("R1 busy", int'(conv_busy), 0);
    chk("R1 valid", int'(chan_valid), 0);
    // first frame shifts out the reset word (zero) - R1
    frame(1'b0, 1'b1, 4'hA, 10);
    frame(1'b0, 1'b0, 4'h5, 10);
    frame(1'b1, 1'b1, 4'hC, 10);
    frame(1'b1, 1'b0, 4'h3, 10);
    // aborts just before the closing edge, then the old word must reappear (R7)
    frame(1'b0, 1'b1, 4'h9, 9);
    frame(1'b0, 1'b0, 4'h6, 10);
    frame(1'b1, 1'b0, 4'hF, 9);
    frame(1'b1, 1'b1, 4'h0, 3);
    frame(1'b1, 1'b1, 4'h1, 10);
    for (int i = 0; i < 12; i++)
      frame(1'($urandom), 1'($urandom), 4'($urandom), 10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule